// File: doc/BRIEF.md
# Decoded-Op Line Builder

While the front end runs in build mode, each decoded instruction is handed to this block in the same cycle that its micro-ops go downstream. The block appends those micro-ops to an open line of fixed width. When the line has to close, the block presents it on a write channel to the micro-op cache, together with the line's tag, its count of occupied slots and the total byte length of the instructions it holds. A line closes when the next instruction does not fit, when a new basic block begins, or when the current instruction ends a basic block.

Two separate write channels are used. The displacement channel carries a line that an incoming instruction pushed out. The flush channel carries a line that the current instruction ends. Both channels can fire in one cycle. A microcoded instruction uses a single pointer slot, however many micro-ops it expands to.

An optional filter keeps a saturating counter for each instruction-cache line. A finished line reaches the cache only if its counter has reached a programmable threshold. A separate input clears a counter when its instruction-cache line is replaced.

Top module: `uop_line_builder`

## Requirements
- R1: After reset no line is open, so an instruction without the block-start flag does not produce a displacement write. All access counters read zero after reset.
- R2: A simple instruction of 1 to 4 micro-ops fills consecutive slots, starting right after the last occupied slot. Micro-op k comes from `in_uops[k*16 +: 16]`. Each such slot has kind code 2'b01 in slot bits [17:16], with the micro-op in bits [15:0].
- R3: An instruction needs 1 slot if it is microcoded, and `in_nuops` slots otherwise. If the open line's used count plus that need exceeds 6, the open line is written on the displacement channel in the same cycle, and the instruction starts a new line at slot 0. An exact fit of 6 still appends.
- R4: An instruction with `in_bb_start` set while a line is open sends that line out on the displacement channel in the same cycle. The instruction then starts a new line.
- R5: An instruction with `in_bb_end` set causes the line that contains it to be written on the flush channel in that same cycle. The next instruction finds no line open.
- R6: When one instruction both displaces an open line and ends its basic block, both channels are valid in that cycle. The displacement channel carries the old line. The flush channel carries a new line that holds only this instruction.
- R7: A written line's tag is the IP of its first instruction. Its count equals the number of occupied slots, and its byte field is the sum of its instructions' lengths. Slot i sits at bits [i*18 +: 18] of the slot bus, and unused slots are all zero.
- R8: A microcoded instruction (`in_complex`=1) takes exactly one slot. That slot has kind code 2'b10, and its payload is `in_uops[15:0]`, the sequencer entry point.
- R9: Each counter belongs to the instruction-cache line given by tag bits [9:4]. It increments once for every line started there and saturates at `thresh`. With `filt_en`=0 every closed line is written. With `filt_en`=1 a line is written only if its counter, after this line's increment, is at or above `thresh`. Otherwise the channel's valid stays low.
- R10: `inv_valid` clears the counter selected by `inv_idx`. If a line start hits the same counter in the same cycle, the clear applies first, so the counter ends at 1.
- R11: In a cycle with `in_valid` low, neither channel is valid and the open line is kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_en | input | 1 | Enable access-counter filtering of writes |
| thresh | input | 4 | Counter threshold for a write |
| inv_valid | input | 1 | Instruction-cache line replaced |
| inv_idx | input | 6 | Index of the replaced instruction-cache line |
| in_valid | input | 1 | Decoded instruction present |
| in_ip | input | 32 | Instruction address |
| in_len | input | 4 | Instruction byte length |
| in_nuops | input | 3 | Micro-op count (1 to 4 for simple) |
| in_complex | input | 1 | Microcoded instruction |
| in_bb_start | input | 1 | First instruction of a basic block |
| in_bb_end | input | 1 | Last instruction of a basic block |
| in_uops | input | 64 | Up to four 16-bit micro-ops |
| disp_valid | output | 1 | Displaced line write |
| disp_tag | output | 32 | Displaced line tag |
| disp_count | output | 3 | Displaced line slot count |
| disp_bytes | output | 7 | Displaced line byte total |
| disp_slots | output | 108 | Displaced line slots |
| term_valid | output | 1 | Block-end line write |
| term_tag | output | 32 | Block-end line tag |
| term_count | output | 3 | Block-end line slot count |
| term_bytes | output | 7 | Block-end line byte total |
| term_slots | output | 108 | Block-end line slots |

## Verification
Two closes can coincide in one cycle: pushing out the open line and flushing the line that ends at the current instruction. The bench provokes this by opening a two-slot line and then sending one instruction with both block-start and block-end set. It judges the cycle by checking that the displacement channel shows the old tag and count, and that the flush channel shows a one-slot line tagged with the new IP. A second coincidence is also exercised: a counter clear and a line start that hit the same counter in one cycle. The bench checks the two write decisions that follow it.

// File: rtl/ulb_pkg.sv
package ulb_pkg;
    localparam int LINE_SLOTS     = 6;
    localparam int MAX_SIMPLE     = 4;
    localparam int UOP_W          = 16;
    localparam int IP_W           = 32;
    localparam int LEN_W          = 4;
    localparam int MAX_INSN_BYTES = 15;
    localparam int NU_W           = 3;
    localparam int CNT_W          = 4;
    localparam int OFF_W          = 4;
    localparam int IDX_W          = 6;
    localparam int KIND_W         = 2;

    localparam int SLOT_CNT_W = $clog2(LINE_SLOTS + 1);
    localparam int BYTES_W    = $clog2(LINE_SLOTS * MAX_INSN_BYTES + 1);
    localparam int SLOT_W     = KIND_W + UOP_W;
    localparam int IC_LINES   = 1 << IDX_W;
    localparam int UIDX_W     = $clog2(MAX_SIMPLE);

    typedef enum logic [KIND_W-1:0] {
        SK_EMPTY = 2'b00,
        SK_UOP   = 2'b01,
        SK_MSEQ  = 2'b10
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e           kind;
        logic [UOP_W-1:0]     payload;
    } slot_t;

    typedef struct packed {
        logic [IP_W-1:0]                  ip;
        logic [LEN_W-1:0]                 len;
        logic [NU_W-1:0]                  nuops;
        logic                             complex_op;
        logic                             bb_start;
        logic                             bb_end;
        logic [MAX_SIMPLE-1:0][UOP_W-1:0] uops;
    } insn_t;

    typedef struct packed {
        logic [IP_W-1:0]             tag;
        logic [SLOT_CNT_W-1:0]       used;
        logic [BYTES_W-1:0]          bytes;
        logic                        keep;
        slot_t [LINE_SLOTS-1:0]      slots;
    } line_t;

    function automatic logic [SLOT_CNT_W-1:0] slots_needed(input insn_t i);
        return i.complex_op ? SLOT_CNT_W'(1) : SLOT_CNT_W'(i.nuops);
    endfunction

    function automatic logic line_fits(input logic [SLOT_CNT_W-1:0] used,
                                       input logic [SLOT_CNT_W-1:0] need);
        return ({1'b0, used} + {1'b0, need}) <= (SLOT_CNT_W+1)'(LINE_SLOTS);
    endfunction

    function automatic logic [IDX_W-1:0] ic_index(input logic [IP_W-1:0] ip);
        return ip[OFF_W +: IDX_W];
    endfunction
endpackage

// File: rtl/ulb_access_filter.sv
module ulb_access_filter
    import ulb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             filt_en,
    input  logic [CNT_W-1:0] thresh,
    input  logic             inv_valid,
    input  logic [IDX_W-1:0] inv_idx,
    output logic             keep
);
    logic [CNT_W-1:0] cnt_q [IC_LINES];
    logic [CNT_W-1:0] seen;
    logic [CNT_W-1:0] bumped;

    // A replacement in the same cycle is applied before the new access counts.
    always_comb begin
        seen   = (inv_valid && inv_idx == start_idx) ? '0 : cnt_q[start_idx];
        bumped = (seen >= thresh) ? seen : seen + CNT_W'(1);
        keep   = !filt_en || (bumped >= thresh);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < IC_LINES; i++) cnt_q[i] <= '0;
        end else begin
            if (inv_valid) cnt_q[inv_idx] <= '0;
            if (start)     cnt_q[start_idx] <= bumped;
        end
    end
endmodule

// File: rtl/ulb_slot_packer.sv
module ulb_slot_packer
    import ulb_pkg::*;
(
    input  line_t                            base,
    input  logic [SLOT_CNT_W-1:0]            need,
    input  logic                             is_cx,
    input  logic [LEN_W-1:0]                 len,
    input  logic [MAX_SIMPLE-1:0][UOP_W-1:0] uops,
    output line_t                            merged
);
    slot_t [LINE_SLOTS-1:0] new_slots;
    logic  [SLOT_CNT_W:0]   lo;
    logic  [SLOT_CNT_W:0]   hi;

    assign lo = {1'b0, base.used};
    assign hi = lo + {1'b0, need};

    for (genvar g = 0; g < LINE_SLOTS; g++) begin : g_slot
        logic [SLOT_CNT_W:0] rel;
        slot_t               sv;
        always_comb begin
            rel = (SLOT_CNT_W+1)'(g) - lo;
            sv  = base.slots[g];
            if ((SLOT_CNT_W+1)'(g) >= lo && (SLOT_CNT_W+1)'(g) < hi) begin
                if (is_cx) begin
                    sv.kind    = SK_MSEQ;
                    sv.payload = uops[0];
                end else if (rel < (SLOT_CNT_W+1)'(MAX_SIMPLE)) begin
                    sv.kind    = SK_UOP;
                    sv.payload = uops[rel[UIDX_W-1:0]];
                end
            end
        end
        assign new_slots[g] = sv;
    end

    always_comb begin
        merged       = base;
        merged.used  = base.used + need;
        merged.bytes = base.bytes + BYTES_W'(len);
        merged.slots = new_slots;
    end
endmodule

// File: rtl/uop_line_builder.sv
module uop_line_builder
    import ulb_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         filt_en,
    input  logic [CNT_W-1:0]             thresh,
    input  logic                         inv_valid,
    input  logic [IDX_W-1:0]             inv_idx,
    input  logic                         in_valid,
    input  logic [IP_W-1:0]              in_ip,
    input  logic [LEN_W-1:0]             in_len,
    input  logic [NU_W-1:0]              in_nuops,
    input  logic                         in_complex,
    input  logic                         in_bb_start,
    input  logic                         in_bb_end,
    input  logic [MAX_SIMPLE*UOP_W-1:0]  in_uops,
    output logic                         disp_valid,
    output logic [IP_W-1:0]              disp_tag,
    output logic [SLOT_CNT_W-1:0]        disp_count,
    output logic [BYTES_W-1:0]           disp_bytes,
    output logic [LINE_SLOTS*SLOT_W-1:0] disp_slots,
    output logic                         term_valid,
    output logic [IP_W-1:0]              term_tag,
    output logic [SLOT_CNT_W-1:0]        term_count,
    output logic [BYTES_W-1:0]           term_bytes,
    output logic [LINE_SLOTS*SLOT_W-1:0] term_slots
);
    insn_t                 ins;
    line_t                 open_q;
    logic                  open_vld_q;
    logic [SLOT_CNT_W-1:0] need;
    logic                  append;
    logic                  displace;
    logic                  start_line;
    logic                  keep_new;
    line_t                 fresh;
    line_t                 base;
    line_t                 merged;

    always_comb begin
        ins.ip         = in_ip;
        ins.len        = in_len;
        ins.nuops      = in_nuops;
        ins.complex_op = in_complex;
        ins.bb_start   = in_bb_start;
        ins.bb_end     = in_bb_end;
        ins.uops       = in_uops;
    end

    assign need       = slots_needed(ins);
    assign append     = in_valid && open_vld_q && !ins.bb_start && line_fits(open_q.used, need);
    assign displace   = in_valid && open_vld_q && !append;
    assign start_line = in_valid && !append;

    ulb_access_filter u_filter (
        .clk       (clk),
        .rst       (rst),
        .start     (start_line),
        .start_idx (ic_index(ins.ip)),
        .filt_en   (filt_en),
        .thresh    (thresh),
        .inv_valid (inv_valid),
        .inv_idx   (inv_idx),
        .keep      (keep_new)
    );

    always_comb begin
        fresh      = '0;
        fresh.tag  = ins.ip;
        fresh.keep = keep_new;
        base       = append ? open_q : fresh;
    end

    ulb_slot_packer u_packer (
        .base   (base),
        .need   (need),
        .is_cx  (ins.complex_op),
        .len    (ins.len),
        .uops   (ins.uops),
        .merged (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            open_vld_q <= 1'b0;
            open_q     <= '0;
        end else if (in_valid) begin
            if (ins.bb_end) begin
                open_vld_q <= 1'b0;
            end else begin
                open_vld_q <= 1'b1;
                open_q     <= merged;
            end
        end
    end

    assign disp_valid = displace && open_q.keep;
    assign disp_tag   = open_q.tag;
    assign disp_count = open_q.used;
    assign disp_bytes = open_q.bytes;
    assign disp_slots = open_q.slots;

    assign term_valid = in_valid && ins.bb_end && merged.keep;
    assign term_tag   = merged.tag;
    assign term_count = merged.used;
    assign term_bytes = merged.bytes;
    assign term_slots = merged.slots;
endmodule

// File: rtl/ulb_checker.sv
module ulb_checker
    import ulb_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  filt_en,
    input logic                  in_valid,
    input logic [IP_W-1:0]       in_ip,
    input logic [NU_W-1:0]       in_nuops,
    input logic                  in_complex,
    input logic                  in_bb_start,
    input logic                  in_bb_end,
    input logic                  disp_valid,
    input logic [SLOT_CNT_W-1:0] disp_count,
    input logic                  term_valid,
    input logic [IP_W-1:0]       term_tag,
    input logic [SLOT_CNT_W-1:0] term_count
);
    logic [SLOT_CNT_W:0] chk_need;
    assign chk_need = in_complex ? (SLOT_CNT_W+1)'(1) : (SLOT_CNT_W+1)'(in_nuops);

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> (!disp_valid && !term_valid));

    p_no_split_r3: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !in_bb_start) |-> (({1'b0, disp_count} + chk_need) > (SLOT_CNT_W+1)'(LINE_SLOTS)));

    p_disp_count_r7: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (disp_count != '0 && disp_count <= SLOT_CNT_W'(LINE_SLOTS)));

    p_term_count_r7: assert property (@(posedge clk) disable iff (rst)
        term_valid |-> (term_count != '0 && term_count <= SLOT_CNT_W'(LINE_SLOTS)));

    p_new_block_tag_r4: assert property (@(posedge clk) disable iff (rst)
        (term_valid && in_bb_start) |-> term_tag == in_ip);

    p_unfiltered_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bb_end && !filt_en) |-> term_valid);

    p_closed_after_end_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bb_end) |=> !disp_valid);
endmodule

bind uop_line_builder ulb_checker u_chk (.*);

// File: tb/tb_uop_line_builder.sv
module tb_uop_line_builder;
    import ulb_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                         rst, filt_en, inv_valid, in_valid;
    logic [CNT_W-1:0]             thresh;
    logic [IDX_W-1:0]             inv_idx;
    logic [IP_W-1:0]              in_ip;
    logic [LEN_W-1:0]             in_len;
    logic [NU_W-1:0]              in_nuops;
    logic                         in_complex, in_bb_start, in_bb_end;
    logic [MAX_SIMPLE*UOP_W-1:0]  in_uops;
    logic                         disp_valid, term_valid;
    logic [IP_W-1:0]              disp_tag, term_tag;
    logic [SLOT_CNT_W-1:0]        disp_count, term_count;
    logic [BYTES_W-1:0]           disp_bytes, term_bytes;
    logic [LINE_SLOTS*SLOT_W-1:0] disp_slots, term_slots;

    uop_line_builder dut (.*);

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [LINE_SLOTS*SLOT_W-1:0] put(input logic [LINE_SLOTS*SLOT_W-1:0] v,
            input int i, input logic [1:0] k, input logic [UOP_W-1:0] p);
        v[i*SLOT_W +: SLOT_W] = {k, p};
        return v;
    endfunction

    task automatic send(input logic [IP_W-1:0] ip, input int len, input int nu,
                        input bit cx, input bit bs, input bit be, input logic [UOP_W-1:0] ub);
        @(negedge clk);
        in_valid = 1'b1; in_ip = ip; in_len = LEN_W'(len); in_nuops = NU_W'(nu);
        in_complex = cx; in_bb_start = bs; in_bb_end = be;
        for (int k = 0; k < MAX_SIMPLE; k++) in_uops[k*UOP_W +: UOP_W] = ub + UOP_W'(k);
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_bb_start = 1'b0; in_bb_end = 1'b0; inv_valid = 1'b0;
        #2;
    endtask

    task automatic t_reset();
        rst = 1'b1; filt_en = 1'b0; thresh = '0; inv_valid = 1'b0; inv_idx = '0;
        in_valid = 1'b0; in_ip = '0; in_len = '0; in_nuops = '0; in_complex = 1'b0;
        in_bb_start = 1'b0; in_bb_end = 1'b0; in_uops = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #2;
        chk("R1 idle disp", disp_valid, 0);
        chk("R1 idle term", term_valid, 0);
        send(32'h40, 1, 1, 0, 0, 1, 16'h5);
        chk("R1 no open line", disp_valid, 0);
        chk("R1 lone line", term_valid, 1);
        chk("R1 lone tag", term_tag, 32'h40);
        idle();
    endtask

    task automatic t_pack();
        logic [LINE_SLOTS*SLOT_W-1:0] e = '0;
        send(32'h100, 3, 2, 0, 1, 0, 16'h10);
        chk("R2 no write mid line", disp_valid | term_valid, 0);
        send(32'h103, 2, 3, 0, 0, 1, 16'h20);
        e = put(e, 0, 2'b01, 16'h10); e = put(e, 1, 2'b01, 16'h11);
        e = put(e, 2, 2'b01, 16'h20); e = put(e, 3, 2'b01, 16'h21);
        e = put(e, 4, 2'b01, 16'h22);
        chk("R5 flush valid", term_valid, 1);
        chk("R7 tag", term_tag, 32'h100);
        chk("R7 count", term_count, 5);
        chk("R7 bytes", term_bytes, 5);
        chk("R2 slots", term_slots, e);
        idle();
    endtask

    task automatic t_overflow();
        send(32'h200, 4, 4, 0, 1, 0, 16'h30);
        send(32'h204, 3, 3, 0, 0, 0, 16'h40);
        chk("R3 displaced", disp_valid, 1);
        chk("R3 displaced tag", disp_tag, 32'h200);
        chk("R3 displaced count", disp_count, 4);
        send(32'h207, 1, 2, 0, 0, 1, 16'h50);
        chk("R3 new line tag", term_tag, 32'h204);
        chk("R3 new line count", term_count, 5);
        chk("R3 new line bytes", term_bytes, 4);
        idle();
        send(32'h300, 4, 4, 0, 1, 0, 16'h60);
        send(32'h304, 2, 2, 0, 0, 1, 16'h70);
        chk("R3 exact fit no displace", disp_valid, 0);
        chk("R3 exact fit count", term_count, 6);
        idle();
    endtask

    task automatic t_complex();
        logic [LINE_SLOTS*SLOT_W-1:0] e = '0;
        send(32'h400, 5, 4, 0, 1, 0, 16'h80);
        send(32'h405, 7, 6, 1, 0, 0, 16'h77);
        chk("R8 pointer fits", disp_valid, 0);
        send(32'h40C, 1, 1, 0, 0, 1, 16'h90);
        for (int k = 0; k < 4; k++) e = put(e, k, 2'b01, 16'h80 + UOP_W'(k));
        e = put(e, 4, 2'b10, 16'h77); e = put(e, 5, 2'b01, 16'h90);
        chk("R8 count", term_count, 6);
        chk("R8 bytes", term_bytes, 13);
        chk("R8 slots", term_slots, e);
        idle();
    endtask

    task automatic t_both();
        send(32'h700, 1, 1, 0, 1, 0, 16'hA0);
        send(32'h800, 1, 1, 0, 1, 0, 16'hA1);
        chk("R4 block start displaces", disp_valid, 1);
        chk("R4 displaced tag", disp_tag, 32'h700);
        send(32'h500, 2, 2, 0, 1, 0, 16'hB0);
        chk("R4 second displace", disp_tag, 32'h800);
        send(32'h600, 2, 1, 0, 1, 1, 16'hC0);
        chk("R6 disp valid", disp_valid, 1);
        chk("R6 disp tag", disp_tag, 32'h500);
        chk("R6 disp count", disp_count, 2);
        chk("R6 term valid", term_valid, 1);
        chk("R6 term tag", term_tag, 32'h600);
        chk("R6 term count", term_count, 1);
        chk("R6 term bytes", term_bytes, 2);
        send(32'h602, 1, 1, 0, 0, 1, 16'hC1);
        chk("R5 nothing open", disp_valid, 0);
        chk("R5 fresh tag", term_tag, 32'h602);
        chk("R5 fresh count", term_count, 1);
        idle();
    endtask

    task automatic t_idle_gap();
        send(32'h900, 2, 2, 0, 1, 0, 16'hD0);
        for (int i = 0; i < 3; i++) begin
            idle();
            chk("R11 idle outputs", disp_valid | term_valid, 0);
        end
        send(32'h902, 1, 1, 0, 0, 1, 16'hD8);
        chk("R11 line kept tag", term_tag, 32'h900);
        chk("R11 line kept count", term_count, 3);
        idle();
    endtask

    task automatic t_filter();
        // 0x1A50 -> counter 0x25, 0x12A0 -> counter 0x2A
        @(negedge clk); filt_en = 1'b1; thresh = 4'd3;
        send(32'h1A50, 1, 1, 0, 1, 1, 16'hE0); chk("R9 first pass dropped", term_valid, 0);
        send(32'h1A50, 1, 1, 0, 1, 1, 16'hE0); chk("R9 second pass dropped", term_valid, 0);
        send(32'h1A50, 1, 1, 0, 1, 1, 16'hE0); chk("R9 threshold written", term_valid, 1);
        send(32'h1A50, 1, 1, 0, 1, 1, 16'hE0); chk("R9 saturated written", term_valid, 1);
        send(32'h12A0, 1, 1, 0, 1, 1, 16'hE1); chk("R9 other line dropped", term_valid, 0);
        idle();
        @(negedge clk); inv_valid = 1'b1; inv_idx = 6'h25;
        idle();
        send(32'h1A50, 1, 1, 0, 1, 1, 16'hE0); chk("R10 cleared counter", term_valid, 0);
        @(negedge clk); thresh = 4'd2;
        send(32'h1A50, 1, 1, 0, 1, 1, 16'hE0);
        inv_valid = 1'b1; inv_idx = 6'h25; #1;
        chk("R10 same-cycle clear counts one", term_valid, 0);
        idle();
        send(32'h1A50, 1, 1, 0, 1, 1, 16'hE0); chk("R10 counter kept after clear", term_valid, 1);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_pack();
        t_overflow();
        t_complex();
        t_both();
        t_idle_gap();
        t_filter();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule